// File: doc/BRIEF.md
# Flag-Predicated Accumulator Thread Unit

This block is one execution thread of a pipelined string-processing engine. It takes at most one 10-bit opcode per clock step and works on a 16-bit accumulator, a private 32-entry scratchpad and a bank of seven one-bit condition flags. The opcodes cover scratchpad load and store, arithmetic and logic against a scratchpad entry, a 5-bit immediate load, accumulator-only operations, flag tests and flag writes. Two requests leave the block: adding the accumulator to the source pointer or to the destination pointer.

The opcodes execute-if-clear and execute-if-set start a predicated region. Later opcodes are skipped until the next such opcode or until the enclosing pipeline cycle ends, so regions never nest. The surrounding sequencer marks the end of each cycle with a strobe and the start of each new instruction with another strobe. Opcodes it does not handle, such as branches, thread switches and type changes, have no effect.

Top module: `atu_thread`

## Requirements
- R1: After reset the accumulator, all flags, every scratchpad entry and div_err_o are zero, and neither pointer request is raised.
- R2: Opcode 00100iiiii loads the accumulator with iiiii, zero-extended. The result appears on acc_o after the clock edge at which the opcode is sampled with op_valid_i high.
- R3: Opcode 10011nnnnn writes the accumulator into scratchpad entry nnnnn. Opcode 10010nnnnn loads the accumulator from entry nnnnn.
- R4: With scratchpad entry nnnnn as operand, the prefixes 10100 add, 10101 subtract (accumulator minus entry), 11000 AND, 11001 OR and 11010 XOR update the accumulator. Add and subtract wrap modulo 2^16.
- R5: Prefix 10110 multiplies and keeps the low 16 bits. Prefix 10111 divides unsigned and keeps the quotient. A divide by a zero entry leaves the accumulator unchanged and sets div_err_o, which stays set until start_i or reset.
- R6: Opcode 0000000001 swaps the accumulator bytes, 0000000010 increments it with wrap, and 0000000011 inverts every bit.
- R7: Opcode 0000000100 raises src_add_o and 0000000101 raises dst_add_o, each for exactly one cycle, with ptr_delta_o holding the accumulator value at the time the opcode was sampled.
- R8: Opcodes 0001000aaa, 0001001aaa and 0001010aaa write into flag aaa the result (1 or 0) of the test "accumulator signed greater than zero", "accumulator is zero" and "accumulator bit 15 set" respectively. Flag k appears on flags_o bit k-1. Writes to flag 0 are ignored.
- R9: Opcode 0001100aaa clears flag aaa and 0001101aaa sets it.
- R10: Opcode 0001110aaa (execute-if-clear) makes the following opcodes be skipped if flag aaa is 1. Opcode 0001111aaa (execute-if-set) makes them be skipped if flag aaa is 0. Flag 0 reads as 0, so 0001110000 always resumes and 0001111000 always skips. These two opcodes are evaluated even inside a skipped region, and each replaces the previous region. A cycle_end_i strobe ends skipping after the opcode sampled with it.
- R11: start_i clears all flags, ends any skipped region and clears div_err_o, and leaves the accumulator and scratchpad unchanged.
- R12: Every opcode not named in R2 to R10 is a no-operation. This includes the branch prefixes 00101, 00110 and 00111, the thread-switch prefix 01, and the fixed codes 0000000110 upward.
- R13: While op_valid_i is low, the opcode input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | New instruction: clear flags, predication and error |
| op_i | input | 10 | Opcode |
| op_valid_i | input | 1 | Opcode valid this step |
| cycle_end_i | input | 1 | Last step of the current pipeline cycle |
| acc_o | output | 16 | Accumulator |
| flags_o | output | 7 | Flags 1 to 7 on bits 0 to 6 |
| src_add_o | output | 1 | Request to add ptr_delta_o to the source pointer |
| dst_add_o | output | 1 | Request to add ptr_delta_o to the destination pointer |
| ptr_delta_o | output | 16 | Amount for the pointer request |
| div_err_o | output | 1 | Sticky divide-by-zero indicator |

## Verification
The bench builds the unit with its default parameters: a 16-bit datapath and 32 scratchpad entries. With these values the 5-bit index field reaches every scratchpad entry, and a directed sequence can build 0x8000, so the sign-bit boundary of the flag tests is exercised as well as zero and all-ones. Random opcode streams with sparse cycle-end and start strobes drive predication regions that overlap both kinds of terminator. Every step is compared against a bench-side model of the opcode set.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int OP_W       = 10;
  localparam int FIELD_W    = 5;
  localparam int FSEL_W     = 3;
  localparam int NUM_FLAGS  = 7;

  typedef enum logic [4:0] {
    K_NOP, K_SWAP, K_INC, K_INV, K_ASP, K_ADP,
    K_SFP, K_SFZ, K_SFN, K_CF, K_SF, K_XC, K_XS,
    K_IMM, K_LD, K_ST, K_ADD, K_SUB, K_MUL, K_DIV,
    K_AND, K_OR, K_XOR
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [FIELD_W-1:0]  field;
  } dec_t;
endpackage

// File: rtl/atu_decode.sv
module atu_decode
  import atu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);
  always_comb begin
    dec_o.field = op_i[FIELD_W-1:0];
    dec_o.kind  = K_NOP;
    casez (op_i)
      10'b00000_00001: dec_o.kind = K_SWAP;
      10'b00000_00010: dec_o.kind = K_INC;
      10'b00000_00011: dec_o.kind = K_INV;
      10'b00000_00100: dec_o.kind = K_ASP;
      10'b00000_00101: dec_o.kind = K_ADP;
      10'b0001000???:  dec_o.kind = K_SFP;
      10'b0001001???:  dec_o.kind = K_SFZ;
      10'b0001010???:  dec_o.kind = K_SFN;
      10'b0001100???:  dec_o.kind = K_CF;
      10'b0001101???:  dec_o.kind = K_SF;
      10'b0001110???:  dec_o.kind = K_XC;
      10'b0001111???:  dec_o.kind = K_XS;
      10'b00100?????:  dec_o.kind = K_IMM;
      10'b10010?????:  dec_o.kind = K_LD;
      10'b10011?????:  dec_o.kind = K_ST;
      10'b10100?????:  dec_o.kind = K_ADD;
      10'b10101?????:  dec_o.kind = K_SUB;
      10'b10110?????:  dec_o.kind = K_MUL;
      10'b10111?????:  dec_o.kind = K_DIV;
      10'b11000?????:  dec_o.kind = K_AND;
      10'b11001?????:  dec_o.kind = K_OR;
      10'b11010?????:  dec_o.kind = K_XOR;
      default:         dec_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/atu_alu.sv
module atu_alu
  import atu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  kind_e              kind_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic [DATA_W-1:0]  opnd_i,
  output logic [DATA_W-1:0]  res_o,
  output logic               wr_o,
  output logic               div_zero_o
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    res_o      = acc_i;
    wr_o       = 1'b1;
    div_zero_o = 1'b0;
    unique case (kind_i)
      K_SWAP: res_o = {acc_i[HALF_W-1:0], acc_i[DATA_W-1:HALF_W]};
      K_INC:  res_o = acc_i + 1'b1;
      K_INV:  res_o = ~acc_i;
      K_IMM:  res_o = {{(DATA_W-FIELD_W){1'b0}}, field_i};
      K_LD:   res_o = opnd_i;
      K_ADD:  res_o = acc_i + opnd_i;
      K_SUB:  res_o = acc_i - opnd_i;
      K_MUL:  res_o = acc_i * opnd_i;
      K_DIV: begin
        if (opnd_i == '0) begin
          wr_o       = 1'b0;
          div_zero_o = 1'b1;
        end else begin
          res_o = acc_i / opnd_i;
        end
      end
      K_AND:  res_o = acc_i & opnd_i;
      K_OR:   res_o = acc_i | opnd_i;
      K_XOR:  res_o = acc_i ^ opnd_i;
      default: wr_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/atu_pred.sv
module atu_pred
  import atu_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 cycle_end_i,
  input  logic                 valid_i,
  input  kind_e                kind_i,
  input  logic [FSEL_W-1:0]    fsel_i,
  input  logic                 acc_pos_i,
  input  logic                 acc_zero_i,
  input  logic                 acc_neg_i,
  output logic                 exec_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 skip_q;
  logic [FSEL_W-1:0]    fpos;
  logic                 flag_rd, is_pred, fwr_kind, fwr_val;

  assign is_pred = (kind_i == K_XC) || (kind_i == K_XS);
  assign exec_o  = valid_i && (!skip_q || is_pred);
  assign fpos    = fsel_i - 1'b1;
  assign flag_rd = (fsel_i != '0) ? flags_q[fpos] : 1'b0;
  assign flags_o = flags_q;

  always_comb begin
    fwr_kind = 1'b1;
    fwr_val  = 1'b0;
    case (kind_i)
      K_SFP:   fwr_val = acc_pos_i;
      K_SFZ:   fwr_val = acc_zero_i;
      K_SFN:   fwr_val = acc_neg_i;
      K_CF:    fwr_val = 1'b0;
      K_SF:    fwr_val = 1'b1;
      default: fwr_kind = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      skip_q  <= 1'b0;
    end else if (start_i) begin
      flags_q <= '0;
      skip_q  <= 1'b0;
    end else begin
      if (exec_o && fwr_kind && fsel_i != '0) flags_q[fpos] <= fwr_val;
      if (exec_o && kind_i == K_XC) skip_q <= flag_rd;
      if (exec_o && kind_i == K_XS) skip_q <= !flag_rd;
      if (cycle_end_i) skip_q <= 1'b0;  // region never outlives its cycle
    end
  end

  p_start_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (flags_q == '0) && !skip_q);
  p_cycle_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_end_i |=> !skip_q);
  p_xc0_resume_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == K_XC && fsel_i == '0) |=> !skip_q);
  p_flag0_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwr_kind && fsel_i == '0 && !start_i) |=> $stable(flags_q));
endmodule

// File: rtl/atu_thread.sv
module atu_thread
  import atu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SP_DEPTH = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic                 op_valid_i,
  input  logic                 cycle_end_i,
  output logic [DATA_W-1:0]    acc_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 src_add_o,
  output logic                 dst_add_o,
  output logic [DATA_W-1:0]    ptr_delta_o,
  output logic                 div_err_o
);
  localparam int IDX_W = $clog2(SP_DEPTH);

  dec_t              dec;
  logic [IDX_W-1:0]  sp_idx;
  logic [DATA_W-1:0] acc_q, alu_res, opnd;
  logic [DATA_W-1:0] sp_q [SP_DEPTH];
  logic              alu_wr, div_zero, exec;

  atu_decode u_dec (.op_i(op_i), .dec_o(dec));

  assign sp_idx = dec.field[IDX_W-1:0];
  assign opnd   = sp_q[sp_idx];

  atu_alu #(.DATA_W(DATA_W)) u_alu (
    .kind_i(dec.kind), .field_i(dec.field), .acc_i(acc_q), .opnd_i(opnd),
    .res_o(alu_res), .wr_o(alu_wr), .div_zero_o(div_zero)
  );

  atu_pred u_pred (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cycle_end_i(cycle_end_i),
    .valid_i(op_valid_i), .kind_i(dec.kind), .fsel_i(dec.field[FSEL_W-1:0]),
    .acc_pos_i(!acc_q[DATA_W-1] && (acc_q != '0)),
    .acc_zero_i(acc_q == '0),
    .acc_neg_i(acc_q[DATA_W-1]),
    .exec_o(exec), .flags_o(flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      div_err_o   <= 1'b0;
      src_add_o   <= 1'b0;
      dst_add_o   <= 1'b0;
      ptr_delta_o <= '0;
      for (int i = 0; i < SP_DEPTH; i++) sp_q[i] <= '0;
    end else begin
      src_add_o <= 1'b0;
      dst_add_o <= 1'b0;
      if (start_i) div_err_o <= 1'b0;
      if (exec) begin
        if (alu_wr) acc_q <= alu_res;
        if (dec.kind == K_ST) sp_q[sp_idx] <= acc_q;
        if (div_zero && !start_i) div_err_o <= 1'b1;
        if (dec.kind == K_ASP) begin
          src_add_o   <= 1'b1;
          ptr_delta_o <= acc_q;
        end
        if (dec.kind == K_ADP) begin
          dst_add_o   <= 1'b1;
          ptr_delta_o <= acc_q;
        end
      end
    end
  end

  assign acc_o = acc_q;

  p_div_zero_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && dec.kind == K_DIV && opnd == '0 && !start_i) |=> $stable(acc_q) && div_err_o);
  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_err_o && !start_i) |=> div_err_o);
  p_src_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && dec.kind == K_ASP) |=> src_add_o && !dst_add_o && ptr_delta_o == $past(acc_q));
  p_skip_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !exec) |=> $stable(acc_q) && !src_add_o && !dst_add_o);
  p_invalid_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> $stable(acc_q) && !src_add_o && !dst_add_o);
endmodule

// File: tb/atu_thread_tb_top.sv
module atu_thread_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, valid = 1'b0, cend = 1'b0;
  logic [9:0]  op = '0;
  logic [15:0] acc, delta;
  logic [6:0]  flags;
  logic        src_add, dst_add, div_err;

  always #4 clk = ~clk;

  atu_thread dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .op_valid_i(valid),
    .cycle_end_i(cend), .acc_o(acc), .flags_o(flags), .src_add_o(src_add),
    .dst_add_o(dst_add), .ptr_delta_o(delta), .div_err_o(div_err)
  );

  int checks = 0, errors = 0;
  logic [15:0] m_acc, m_delta;
  logic [15:0] m_sp [32];
  logic [7:0]  m_fl;
  logic        m_skip, m_err, m_src, m_dst;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input logic [4:0] p, input logic [4:0] f);
    return {p, f};
  endfunction

  task automatic model_step(input logic [9:0] o, input logic v, input logic ce, input logic st);
    logic [4:0]  p = o[9:5], lo = o[4:0];
    logic [2:0]  s = o[2:0];
    logic [15:0] x = m_sp[lo];
    logic        ex, c;
    m_src = 1'b0;
    m_dst = 1'b0;
    if (st) begin
      m_fl = '0; m_skip = 1'b0; m_err = 1'b0;
    end else begin
      ex = v && (!m_skip || o[9:4] == 6'b000111);
      if (ex) begin
        case (p)
          5'd0: case (lo)
            5'd1: m_acc = {m_acc[7:0], m_acc[15:8]};
            5'd2: m_acc = m_acc + 16'd1;
            5'd3: m_acc = ~m_acc;
            5'd4: begin m_src = 1'b1; m_delta = m_acc; end
            5'd5: begin m_dst = 1'b1; m_delta = m_acc; end
            default: ;
          endcase
          5'd2: if (o[4:3] != 2'b11) begin
            c = (o[4:3] == 2'b00) ? ($signed(m_acc) > 0) :
                (o[4:3] == 2'b01) ? (m_acc == 0) : m_acc[15];
            if (s != 0) m_fl[s] = c;
          end
          5'd3: case (o[4:3])
            2'b00: if (s != 0) m_fl[s] = 1'b0;
            2'b01: if (s != 0) m_fl[s] = 1'b1;
            2'b10: m_skip = (s == 0) ? 1'b0 : m_fl[s];
            default: m_skip = (s == 0) ? 1'b1 : !m_fl[s];
          endcase
          5'd4:  m_acc = {11'd0, lo};
          5'd18: m_acc = x;
          5'd19: m_sp[lo] = m_acc;
          5'd20: m_acc = m_acc + x;
          5'd21: m_acc = m_acc - x;
          5'd22: m_acc = m_acc * x;
          5'd23: if (x == 0) m_err = 1'b1; else m_acc = m_acc / x;
          5'd24: m_acc = m_acc & x;
          5'd25: m_acc = m_acc | x;
          5'd26: m_acc = m_acc ^ x;
          default: ;
        endcase
      end
      if (ce) m_skip = 1'b0;
    end
  endtask

  task automatic step(input string tag, input logic [9:0] o, input logic v = 1'b1,
                      input logic ce = 1'b0, input logic st = 1'b0);
    op = o; valid = v; cend = ce; start = st;
    @(negedge clk);
    model_step(o, v, ce, st);
    chk(tag, {acc, flags, div_err, src_add, dst_add}, {m_acc, m_fl[7:1], m_err, m_src, m_dst});
    if (m_src || m_dst) chk(tag, delta, m_delta);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  function automatic logic [9:0] rnd_op();
    int r = $urandom_range(0, 9);
    case (r)
      0: return mk(5'd0, 5'($urandom_range(0, 6)));
      1: return mk(5'd2, 5'($urandom_range(0, 31)));
      2: return mk(5'd3, 5'($urandom_range(0, 31)));
      3: return mk(5'd4, 5'($urandom_range(0, 31)));
      9: return 10'($urandom_range(0, 1023));
      default: return mk(5'($urandom_range(18, 26)), 5'($urandom_range(0, 7)));
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    m_acc = '0; m_delta = '0; m_fl = '0; m_skip = 0; m_err = 0; m_src = 0; m_dst = 0;
    for (int i = 0; i < 32; i++) m_sp[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acc", acc, 0);
    chk("R1 flags", flags, 0);
    chk("R1 err/req", {div_err, src_add, dst_add}, 0);
    step("R1 sp zero", mk(5'd18, 5'd9));
    // R2 immediate
    step("R2", mk(5'd4, 5'd31));
    chk("R2 imm31", acc, 16'd31);
    // R3 store/load
    step("R3", mk(5'd19, 5'd3));
    step("R3", mk(5'd4, 5'd0));
    step("R3", mk(5'd18, 5'd3));
    chk("R3 load", acc, 16'd31);
    // R4 arithmetic / logic
    step("R4", mk(5'd4, 5'd7));
    step("R4", mk(5'd20, 5'd3));
    chk("R4 add", acc, 16'd38);
    step("R4", mk(5'd21, 5'd3));
    step("R4", mk(5'd21, 5'd3));
    chk("R4 sub wrap", acc, 16'hFFE8);
    step("R4", mk(5'd24, 5'd3));
    step("R4", mk(5'd25, 5'd3));
    step("R4", mk(5'd26, 5'd3));
    // R5 multiply / divide
    step("R5", mk(5'd4, 5'd6));
    step("R5", mk(5'd19, 5'd4));
    step("R5", mk(5'd4, 5'd27));
    step("R5", mk(5'd22, 5'd4));
    chk("R5 mul", acc, 16'd162);
    step("R5", mk(5'd23, 5'd4));
    chk("R5 div", acc, 16'd27);
    step("R5 div0", mk(5'd23, 5'd10));
    chk("R5 div0 acc", {acc, div_err}, {16'd27, 1'b1});
    step("R5 sticky", mk(5'd0, 5'd0));
    step("R11 clears err", 10'd0, 1'b0, 1'b0, 1'b1);
    chk("R11 err", {div_err, acc}, {1'b0, 16'd27});
    // R6 fixed codes
    step("R6 swap", mk(5'd0, 5'd1));
    chk("R6 swap", acc, 16'h1B00);
    step("R6 inc", mk(5'd0, 5'd2));
    step("R6 inv", mk(5'd0, 5'd3));
    chk("R6 inv", acc, 16'hE4FE);
    // R7 pointer requests
    step("R7 src", mk(5'd0, 5'd4));
    step("R7 dst", mk(5'd0, 5'd5));
    step("R7 one pulse", mk(5'd0, 5'd0));
    // R8 flag tests incl. sign boundary
    step("R8", mk(5'd4, 5'd0));
    step("R8 zero", mk(5'd2, 5'b01001));
    step("R8 pos0", mk(5'd2, 5'b00010));
    step("R8 neg0", mk(5'd2, 5'b10011));
    step("R8", mk(5'd0, 5'd3));
    step("R8 neg", mk(5'd2, 5'b10011));
    step("R8 zero clr", mk(5'd2, 5'b01001));
    step("R8 flag0", mk(5'd2, 5'b10000));
    step("R8", mk(5'd4, 5'd8));
    step("R8", mk(5'd19, 5'd8));
    step("R8", mk(5'd4, 5'd16));
    step("R8", mk(5'd22, 5'd8));
    step("R8", mk(5'd19, 5'd11));
    step("R8", mk(5'd4, 5'd1));
    step("R8", mk(5'd0, 5'd1));
    step("R8", mk(5'd22, 5'd11));
    chk("R8 build 8000", acc, 16'h8000);
    step("R8 pos min", mk(5'd2, 5'b00010));
    step("R8 neg min", mk(5'd2, 5'b10011));
    chk("R8 flags", flags, 7'b0000100);
    // R9 set/clear
    step("R9 set", mk(5'd3, 5'b01101));
    step("R9 clr", mk(5'd3, 5'b00101));
    step("R9 set7", mk(5'd3, 5'b01111));
    // R10 predication
    step("R10", mk(5'd3, 5'b01100));
    step("R10 xs taken", mk(5'd3, 5'b11100));
    step("R10 exec", mk(5'd4, 5'd9));
    step("R10 xc skip", mk(5'd3, 5'b10100));
    step("R10 skipped imm", mk(5'd4, 5'd3));
    chk("R10 skipped", acc, 16'd9);
    step("R10 skipped st", mk(5'd19, 5'd12));
    step("R10 skipped sf", mk(5'd3, 5'b01110));
    step("R10 skipped asp", mk(5'd0, 5'd4));
    step("R10 xc0", mk(5'd3, 5'b10000));
    step("R10 resumed", mk(5'd4, 5'd2));
    step("R10", mk(5'd18, 5'd12));
    step("R10 xc clear", mk(5'd3, 5'b10101));
    step("R10 exec", mk(5'd0, 5'd2));
    step("R10 xs0", mk(5'd3, 5'b11000));
    step("R10 skip at end", mk(5'd4, 5'd5), 1'b1, 1'b1);
    step("R10 after end", mk(5'd4, 5'd6));
    chk("R10 after end", acc, 16'd6);
    // R11 start
    step("R11", mk(5'd3, 5'b01001));
    step("R11 start", 10'd0, 1'b0, 1'b0, 1'b1);
    chk("R11 flags", {flags, acc}, {7'd0, 16'd6});
    // R12 unsupported codes
    step("R12 cyc", 10'b0010100011);
    step("R12 lf", 10'b0011000001);
    step("R12 lp", 10'b0011100010);
    step("R12 stc", 10'b0100100101);
    step("R12 gcc", 10'b0000000110);
    step("R12 hi", 10'b1101100001);
    step("R12 gap", 10'b0001011001);
    chk("R12 acc", acc, 16'd6);
    // R13 invalid
    step("R13", mk(5'd4, 5'd17), 1'b0);
    chk("R13 acc", acc, 16'd6);
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic st = ($urandom_range(0, 199) == 0);
      logic v  = st ? 1'b0 : ($urandom_range(0, 7) != 0);
      logic ce = ($urandom_range(0, 5) == 0);
      step("RND", rnd_op(), v, ce, st);
    end
    valid = 1'b0;
    summary();
  end
endmodule